// File: doc/BRIEF.md
# Display Interrupt Aggregation Controller

This block collects interrupt requests from display pipes, a port hotplug detector and a set of general engine event lines. It folds them into one 32-bit pending-identity register and drives a single interrupt output to the host. Each display pipe has its own status register. Its sticky status bits latch events, and its enable bits decide which of those events raise the pipe's summary. A rising summary sets the pipe's bit in the identity register once, as an edge. The hotplug source works differently. It has a sticky status register and an enable register, and it keeps its identity bit asserted for as long as an enabled status bit is pending.

Software uses a plain 32-bit register bus. The bus has a write strobe, a byte address and write data, and the read data is combinational. The identity register and all status registers are cleared by writing ones. A mask register stops a source from entering the identity register, and an enable register chooses which pending bits drive the output. A parameter selects the output variant. The level variant holds the line high while any enabled pending bit exists. The message variant emits a one-cycle pulse only when the enabled pending set goes from empty to non-empty.

Top module: `disp_irq_agg`

## Requirements
- R1: After reset the mask register (offset 0x04) reads all ones, and the output enable (0x08), identity (0x00), hotplug enable (0x10), hotplug status (0x14) and pipe status registers (0x20 + 4*p) all read zero. `irq_o` is low.
- R2: In a pipe status register, bits 15..0 and bit 31 are sticky status. An event input bit at one of these positions sets that bit. Writing 1 to the bit clears it, and writing 0 leaves it unchanged. When an event and a clear hit the same cycle, the bit ends up set.
- R3: Pipe enable bits 30..16 are read/write through the bus and cannot be set by events. Enable bit k+16 gates status bit k for k = 0..14. Status bits 15 and 31 have no enable and never raise the pipe summary.
- R4: Identity bit 4+p is set one cycle after the pipe-p summary (OR of enabled status bits 14..0) rises. Once software clears that identity bit, it stays clear while the summary stays high. A new rise after the status has been cleared sets it again.
- R5: Hotplug status bits latch events and are cleared by writing 1. Identity bit 7 is set on every cycle in which the hotplug status AND its enable is nonzero, so clearing bit 7 has no effect while that condition holds.
- R6: Engine event input i sets identity bit i at the next clock edge.
- R7: A mask bit at 1 stops its source from setting the matching identity bit. Writing 1 to an identity bit clears it, and a set arriving in the same cycle wins.
- R8: In the level variant, `irq_o` is high exactly while (identity AND output enable) is nonzero.
- R9: In the message variant, `irq_o` pulses for one cycle when (identity AND output enable) goes from zero to nonzero. It does not pulse again while that value stays nonzero.
- R10: A read of the identity register returns the current pending set. A read of an unmapped offset returns zero, and a write to an unmapped offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| pipe_evt_i | input | NUM_PIPES*32 | Per-pipe event bits, 32 per pipe, aligned with the status positions |
| hp_evt_i | input | HP_W | Hotplug event bits |
| ext_evt_i | input | NUM_EXT | Engine event lines |
| irq_o | output | 1 | Interrupt line (level) or one-cycle message pulse |

## Verification
Register resets, read/write masks and unmapped offsets are swept with a table of bus accesses. Directed cases then compare the three ways a source can reach the identity register. The edge-fed pipe bit must not come back after a clear while its status stays pending, but it does return after a fresh rise. The hotplug bit, which tracks a level, must survive a clear. An engine line sets its bit at once, which exposes the extra register stage on the other two paths. Cases where a clear and an event meet in the same cycle, where a source is masked, and where the output enable is changed show apart set-wins ordering, masking and output gating. Both output variants run side by side on the same stimulus, so a second pending bit must leave the message output quiet while the level output stays high.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

   localparam int unsigned REG_W     = 32;
   localparam int unsigned EN_SHIFT  = 16;
   localparam int unsigned GATED_N   = 15;

   localparam logic [REG_W-1:0] PST_STATUS_M = 32'h8000_FFFF;
   localparam logic [REG_W-1:0] PST_ENABLE_M = 32'h7FFF_0000;

   typedef enum logic {
      IRQ_LEVEL = 1'b0,
      IRQ_MSG   = 1'b1
   } irq_mode_e;

   function automatic logic pst_summary(input logic [REG_W-1:0] st,
                                        input logic [REG_W-1:0] en);
      return |(st[GATED_N-1:0] & en[EN_SHIFT+GATED_N-1:EN_SHIFT]);
   endfunction

endpackage

// File: rtl/disp_pipe_stat.sv
module disp_pipe_stat
   import disp_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] evt,
   output logic [REG_W-1:0] reg_q,
   output logic             rise
);

   logic [REG_W-1:0] en_q;
   logic [REG_W-1:0] st_q;
   logic [REG_W-1:0] evt_m;
   logic [REG_W-1:0] clr_m;
   logic             summary;
   logic             summary_q;

   assign evt_m   = evt & PST_STATUS_M;
   assign clr_m   = wr_en ? (wdata & PST_STATUS_M) : '0;
   assign summary = pst_summary(st_q, en_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= '0;
         st_q      <= '0;
         summary_q <= 1'b0;
      end else begin
         if (wr_en) en_q <= wdata & PST_ENABLE_M;
         st_q      <= (st_q & ~clr_m) | evt_m;
         summary_q <= summary;
      end
   end

   assign rise  = summary & ~summary_q;
   assign reg_q = en_q | st_q;

   // R2: an event always leaves its status bit set, even against a clear
   p_status_sticky_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_m) |=> ((st_q & $past(evt_m)) == $past(evt_m)));

   // R4: the edge into the identity register lasts one cycle only
   p_rise_single_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

   // R3: enable field unchanged unless written
   p_enable_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_q));

endmodule

// File: rtl/disp_hp_stat.sv
module disp_hp_stat #(
   parameter int unsigned HP_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_en,
   input  logic            wr_st,
   input  logic [HP_W-1:0] wdata,
   input  logic [HP_W-1:0] evt,
   output logic [HP_W-1:0] en_q,
   output logic [HP_W-1:0] st_q,
   output logic            pending
);

   logic [HP_W-1:0] clr_m;

   assign clr_m = wr_st ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
         st_q <= '0;
      end else begin
         if (wr_en_en) en_q <= wdata;
         st_q <= (st_q & ~clr_m) | evt;
      end
   end

   assign pending = |(st_q & en_q);

   // R5: hotplug events are never lost to a simultaneous clear
   p_hp_sticky_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((st_q & $past(evt)) == $past(evt)));

   // R5: status only drops through a write
   p_hp_clear_by_write_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_st |=> ((st_q & $past(st_q)) == $past(st_q)));

endmodule

// File: rtl/disp_irq_core.sv
module disp_irq_core
   import disp_irq_pkg::*;
#(
   parameter irq_mode_e MODE = IRQ_LEVEL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_req,
   input  logic             wr_iir,
   input  logic             wr_imr,
   input  logic             wr_ier,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] iir_q,
   output logic [REG_W-1:0] imr_q,
   output logic [REG_W-1:0] ier_q,
   output logic             irq_o
);

   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] clr_vec;
   logic             any_act;

   assign set_vec = set_req & ~imr_q;
   assign clr_vec = wr_iir ? wdata : '0;
   assign any_act = |(iir_q & ier_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iir_q <= '0;
         imr_q <= '1;
         ier_q <= '0;
      end else begin
         iir_q <= (iir_q & ~clr_vec) | set_vec;
         if (wr_imr) imr_q <= wdata;
         if (wr_ier) ier_q <= wdata;
      end
   end

   generate
      if (MODE == IRQ_LEVEL) begin : g_level
         assign irq_o = any_act;

         // R8: a fresh rise of the line needs an enabled pending bit
         p_level_rise_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o) |-> ((iir_q & ier_q) != '0));
      end else begin : g_msg
         logic any_q;
         always_ff @(posedge clk) begin
            if (!rst_n) any_q <= 1'b0;
            else        any_q <= any_act;
         end
         assign irq_o = any_act & ~any_q;

         // R9: a message is a single-cycle pulse
         p_msg_one_cycle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |=> !irq_o);
      end
   endgenerate

   // R7: masked sources never appear as new identity bits
   p_iir_masked_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((iir_q & ~$past(iir_q) & $past(imr_q)) == '0));

   // R7: identity bits appear only from a set request
   p_iir_cause_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((iir_q & ~$past(iir_q) & ~$past(set_req)) == '0));

endmodule

// File: rtl/disp_irq_agg.sv
module disp_irq_agg
   import disp_irq_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned NUM_PIPES    = 2,
   parameter int unsigned HP_W         = 8,
   parameter int unsigned NUM_EXT      = 4,
   parameter int unsigned PIPE_IIR_LSB = 4,
   parameter int unsigned HP_IIR_BIT   = 7,
   parameter int unsigned OFS_IIR      = 'h00,
   parameter int unsigned OFS_IMR      = 'h04,
   parameter int unsigned OFS_IER      = 'h08,
   parameter int unsigned OFS_HP_EN    = 'h10,
   parameter int unsigned OFS_HP_ST    = 'h14,
   parameter int unsigned OFS_PIPE     = 'h20,
   parameter int unsigned PIPE_STRIDE  = 'h04,
   parameter irq_mode_e   MODE         = IRQ_LEVEL
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr_en,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [REG_W-1:0]            reg_wdata,
   output logic [REG_W-1:0]            reg_rdata,
   input  logic [NUM_PIPES*REG_W-1:0]  pipe_evt_i,
   input  logic [HP_W-1:0]             hp_evt_i,
   input  logic [NUM_EXT-1:0]          ext_evt_i,
   output logic                        irq_o
);

   localparam logic [ADDR_W-1:0] A_IIR   = ADDR_W'(OFS_IIR);
   localparam logic [ADDR_W-1:0] A_IMR   = ADDR_W'(OFS_IMR);
   localparam logic [ADDR_W-1:0] A_IER   = ADDR_W'(OFS_IER);
   localparam logic [ADDR_W-1:0] A_HP_EN = ADDR_W'(OFS_HP_EN);
   localparam logic [ADDR_W-1:0] A_HP_ST = ADDR_W'(OFS_HP_ST);
   localparam int unsigned       PIPE_TOP = OFS_PIPE + NUM_PIPES * PIPE_STRIDE;

   // elaboration-time parameter checks
   if (NUM_PIPES < 1 || NUM_EXT < 1) begin : g_chk_counts
      $error("disp_irq_agg: NUM_PIPES and NUM_EXT must be at least 1");
   end
   if (HP_W < 1 || HP_W > REG_W) begin : g_chk_hp
      $error("disp_irq_agg: HP_W out of range");
   end
   if (PIPE_IIR_LSB < NUM_EXT || HP_IIR_BIT < PIPE_IIR_LSB + NUM_PIPES
       || HP_IIR_BIT >= REG_W) begin : g_chk_bits
      $error("disp_irq_agg: identity bit assignment overlaps or overflows");
   end
   if (PIPE_TOP > (1 << ADDR_W)) begin : g_chk_addr
      $error("disp_irq_agg: pipe registers exceed address space");
   end

   logic [NUM_PIPES-1:0] pipe_hit;
   logic [NUM_PIPES-1:0] pipe_rise;
   logic [REG_W-1:0]     pipe_reg [NUM_PIPES];
   logic [HP_W-1:0]      hp_en_q;
   logic [HP_W-1:0]      hp_st_q;
   logic                 hp_pend;
   logic [REG_W-1:0]     set_req;
   logic [REG_W-1:0]     iir_q;
   logic [REG_W-1:0]     imr_q;
   logic [REG_W-1:0]     ier_q;

   genvar gp;
   generate
      for (gp = 0; gp < NUM_PIPES; gp++) begin : g_pipe
         assign pipe_hit[gp] = (reg_addr == ADDR_W'(OFS_PIPE + gp * PIPE_STRIDE));

         disp_pipe_stat u_pst (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (reg_wr_en & pipe_hit[gp]),
            .wdata (reg_wdata),
            .evt   (pipe_evt_i[gp*REG_W +: REG_W]),
            .reg_q (pipe_reg[gp]),
            .rise  (pipe_rise[gp])
         );
      end
   endgenerate

   disp_hp_stat #(.HP_W(HP_W)) u_hp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_en (reg_wr_en && reg_addr == A_HP_EN),
      .wr_st    (reg_wr_en && reg_addr == A_HP_ST),
      .wdata    (reg_wdata[HP_W-1:0]),
      .evt      (hp_evt_i),
      .en_q     (hp_en_q),
      .st_q     (hp_st_q),
      .pending  (hp_pend)
   );

   always_comb begin
      set_req                  = '0;
      set_req[NUM_EXT-1:0]     = ext_evt_i;
      for (int p = 0; p < NUM_PIPES; p++) begin
         set_req[PIPE_IIR_LSB + p] = pipe_rise[p];
      end
      set_req[HP_IIR_BIT]      = hp_pend;
   end

   disp_irq_core #(.MODE(MODE)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_req),
      .wr_iir  (reg_wr_en && reg_addr == A_IIR),
      .wr_imr  (reg_wr_en && reg_addr == A_IMR),
      .wr_ier  (reg_wr_en && reg_addr == A_IER),
      .wdata   (reg_wdata),
      .iir_q   (iir_q),
      .imr_q   (imr_q),
      .ier_q   (ier_q),
      .irq_o   (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_IIR)        reg_rdata = iir_q;
      else if (reg_addr == A_IMR)   reg_rdata = imr_q;
      else if (reg_addr == A_IER)   reg_rdata = ier_q;
      else if (reg_addr == A_HP_EN) reg_rdata[HP_W-1:0] = hp_en_q;
      else if (reg_addr == A_HP_ST) reg_rdata[HP_W-1:0] = hp_st_q;
      for (int p = 0; p < NUM_PIPES; p++) begin
         if (pipe_hit[p]) reg_rdata = pipe_reg[p];
      end
   end

   // R4: a pipe identity bit appears only right after that pipe's summary rose
   p_pipe_bit_from_rise_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (iir_q[PIPE_IIR_LSB] && !$past(iir_q[PIPE_IIR_LSB])) |-> $past(pipe_rise[0]));

   // R5: while hotplug is pending and unmasked, its identity bit is held
   p_hp_holds_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (hp_pend && !imr_q[HP_IIR_BIT]) |=> iir_q[HP_IIR_BIT]);

endmodule

// File: tb/disp_irq_agg_bench.sv
module disp_irq_agg_bench;
   import disp_irq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [7:0]     addr = 8'h00;
   logic [31:0]    wdata = '0;
   logic [31:0]    rdata, rdata_m;
   logic [NP*32-1:0] pipe_evt = '0;
   logic [7:0]     hp_evt = '0;
   logic [3:0]     ext_evt = '0;
   logic           irq_lvl, irq_msg;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   disp_irq_agg u_disp_irq_agg (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .pipe_evt_i(pipe_evt),
      .hp_evt_i(hp_evt), .ext_evt_i(ext_evt), .irq_o(irq_lvl));

   disp_irq_agg #(.MODE(IRQ_MSG)) u_disp_irq_agg_msg (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata_m), .pipe_evt_i(pipe_evt),
      .hp_evt_i(hp_evt), .ext_evt_i(ext_evt), .irq_o(irq_msg));

   typedef struct packed {
      logic        rd;
      logic [7:0]  a;
      logic [31:0] d;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 8'h04, 32'h0, 32'hFFFF_FFFF, 4'd1},
      '{1'b1, 8'h08, 32'h0, 32'h0,         4'd1},
      '{1'b1, 8'h00, 32'h0, 32'h0,         4'd1},
      '{1'b1, 8'h10, 32'h0, 32'h0,         4'd1},
      '{1'b1, 8'h14, 32'h0, 32'h0,         4'd1},
      '{1'b1, 8'h20, 32'h0, 32'h0,         4'd1},
      '{1'b1, 8'h24, 32'h0, 32'h0,         4'd1},
      '{1'b1, 8'h3C, 32'h0, 32'h0,         4'd10},
      '{1'b0, 8'h3C, 32'hDEAD_BEEF, 32'h0, 4'd10},
      '{1'b1, 8'h3C, 32'h0, 32'h0,         4'd10},
      '{1'b1, 8'h04, 32'h0, 32'hFFFF_FFFF, 4'd10},
      '{1'b0, 8'h08, 32'h0000_00FF, 32'h0, 4'd8},
      '{1'b1, 8'h08, 32'h0, 32'h0000_00FF, 4'd8},
      '{1'b0, 8'h04, 32'h0, 32'h0,         4'd7},
      '{1'b1, 8'h04, 32'h0, 32'h0,         4'd7},
      '{1'b0, 8'h20, 32'hFFFF_FFFF, 32'h0, 4'd3},
      '{1'b1, 8'h20, 32'h0, 32'h7FFF_0000, 4'd3},
      '{1'b0, 8'h20, 32'h0, 32'h0,         4'd3},
      '{1'b1, 8'h20, 32'h0, 32'h0,         4'd3},
      '{1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0, 4'd5},
      '{1'b1, 8'h10, 32'h0, 32'h0000_00FF, 4'd5},
      '{1'b0, 8'h10, 32'h0, 32'h0,         4'd5}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      addr = a;
      #1;
      chk(req, rdata, exp);
   endtask

   // one clock of stimulus: drive at a falling edge, release at the next
   task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] ext, input logic [NP*32-1:0] pe,
                      input logic [7:0] hp);
      @(negedge clk);
      wr_en = w; addr = a; wdata = d; ext_evt = ext; pipe_evt = pe; hp_evt = hp;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0; ext_evt = '0; pipe_evt = '0; hp_evt = '0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 4'h0, '0, 8'h0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R1 irq low", {31'b0, irq_lvl}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (TBL[i].rd) rd(TBL[i].a, TBL[i].exp, $sformatf("R%0d table %0d", TBL[i].req, i));
         else           wr(TBL[i].a, TBL[i].d);
      end
      // state now: IER=FF, IMR=0, pipe and hotplug enables zero

      // R6 engine event and R8/R9 outputs
      cyc(1'b0, 8'h00, 0, 4'h4, '0, 8'h0);
      rd(8'h00, 32'h4, "R6 ext bit2");
      chk("R8 level high", {31'b0, irq_lvl}, 32'h1);
      chk("R9 msg pulse", {31'b0, irq_msg}, 32'h1);
      idle(1);
      chk("R9 msg one cycle", {31'b0, irq_msg}, 32'h0);
      cyc(1'b0, 8'h00, 0, 4'h2, '0, 8'h0);
      rd(8'h00, 32'h6, "R6 ext bit1");
      chk("R9 no second msg", {31'b0, irq_msg}, 32'h0);
      chk("R8 level still high", {31'b0, irq_lvl}, 32'h1);
      wr(8'h00, 32'h6);
      rd(8'h00, 32'h0, "R7 w1c identity");
      chk("R8 level low", {31'b0, irq_lvl}, 32'h0);

      // R2/R4 pipe edge path
      wr(8'h20, 32'h0008_0000);
      cyc(1'b0, 8'h00, 0, 4'h0, {32'h0, 32'h0000_0008}, 8'h0);
      rd(8'h20, 32'h0008_0008, "R2 sticky capture");
      rd(8'h00, 32'h0, "R4 one-cycle lag");
      idle(1);
      rd(8'h00, 32'h10, "R4 pipe0 bit");
      chk("R9 msg on pipe", {31'b0, irq_msg}, 32'h1);
      wr(8'h00, 32'h10);
      idle(3);
      rd(8'h00, 32'h0, "R4 no re-set while pending");
      wr(8'h20, 32'h0008_0008);
      rd(8'h20, 32'h0008_0000, "R2 w1c status");
      cyc(1'b0, 8'h00, 0, 4'h0, {32'h0, 32'h0000_0008}, 8'h0);
      idle(1);
      rd(8'h00, 32'h10, "R4 new edge");
      wr(8'h20, 32'h0000_FFFF);
      wr(8'h00, 32'h10);

      // R3 ungated status bits; R2 write-zero leaves bits
      wr(8'h24, 32'h7FFF_0000);
      cyc(1'b0, 8'h00, 0, 4'h0, {32'h8000_8000, 32'h0}, 8'h0);
      rd(8'h24, 32'hFFFF_8000, "R3 bits 15 and 31 captured");
      idle(2);
      rd(8'h00, 32'h0, "R3 no summary from 15/31");
      wr(8'h24, 32'h7FFF_8000);
      rd(8'h24, 32'hFFFF_0000, "R2 zero leaves bit31");
      wr(8'h24, 32'hFFFF_0000);
      rd(8'h24, 32'h7FFF_0000, "R2 clear bit31");

      // R2 set wins over same-cycle clear
      cyc(1'b1, 8'h24, 32'h7FFF_0001, 4'h0, {32'h0000_0001, 32'h0}, 8'h0);
      rd(8'h24, 32'h7FFF_0001, "R2 set wins");
      idle(1);
      rd(8'h00, 32'h20, "R4 pipe1 bit");
      wr(8'h24, 32'h0000_FFFF);
      wr(8'h00, 32'h20);
      rd(8'h00, 32'h0, "R7 cleared");

      // R5 hotplug level path
      wr(8'h10, 32'h1);
      cyc(1'b0, 8'h00, 0, 4'h0, '0, 8'h01);
      rd(8'h14, 32'h1, "R5 hp sticky");
      rd(8'h00, 32'h0, "R5 hp lag");
      idle(1);
      rd(8'h00, 32'h80, "R5 hp bit");
      wr(8'h00, 32'h80);
      rd(8'h00, 32'h80, "R5 clear ignored while pending");
      wr(8'h14, 32'h1);
      rd(8'h14, 32'h0, "R5 hp w1c");
      wr(8'h00, 32'h80);
      rd(8'h00, 32'h0, "R5 clear after status");
      cyc(1'b0, 8'h00, 0, 4'h0, '0, 8'h08);
      rd(8'h14, 32'h8, "R5 disabled bit captured");
      idle(2);
      rd(8'h00, 32'h0, "R5 disabled bit no identity");
      wr(8'h14, 32'hFF);

      // R7 masking and set-wins
      wr(8'h04, 32'h1);
      cyc(1'b0, 8'h00, 0, 4'h1, '0, 8'h0);
      rd(8'h00, 32'h0, "R7 masked source");
      cyc(1'b0, 8'h00, 0, 4'h8, '0, 8'h0);
      rd(8'h00, 32'h8, "R7 unmasked source");
      cyc(1'b1, 8'h00, 32'h8, 4'h8, '0, 8'h0);
      rd(8'h00, 32'h8, "R7 set wins over clear");
      wr(8'h00, 32'h8);

      // R8/R9 output enable gating; R10 pending readback
      wr(8'h08, 32'h0);
      cyc(1'b0, 8'h00, 0, 4'h2, '0, 8'h0);
      rd(8'h00, 32'h2, "R10 pending readback");
      chk("R8 gated by enable", {31'b0, irq_lvl}, 32'h0);
      chk("R9 no msg when gated", {31'b0, irq_msg}, 32'h0);
      wr(8'h08, 32'h2);
      chk("R8 enable raises line", {31'b0, irq_lvl}, 32'h1);
      chk("R9 enable raises msg", {31'b0, irq_msg}, 32'h1);
      wr(8'h00, 32'h2);
      chk("R8 line drops", {31'b0, irq_lvl}, 32'h0);

      // R1 mid-run reset
      wr(8'h20, 32'h0001_0000);
      cyc(1'b0, 8'h00, 0, 4'h2, '0, 8'h0);
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      rd(8'h04, 32'hFFFF_FFFF, "R1 mask after reset");
      rd(8'h08, 32'h0, "R1 enable after reset");
      rd(8'h00, 32'h0, "R1 identity after reset");
      rd(8'h20, 32'h0, "R1 pipe after reset");
      chk("R1 irq after reset", {31'b0, irq_lvl}, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule